// File: doc/BRIEF.md
# Distributed-Arithmetic Coefficient Reload Engine

This block takes a fresh set of FIR coefficients over a plain write-enable and data port and turns them into the lookup tables that a distributed-arithmetic filter reads. The taps are split into groups of `TAPS_PER_TBL`. Each group gets its own table of `2^TAPS_PER_TBL` entries, and every entry holds the sum of the coefficients selected by the bits of its address. The coefficients themselves are never stored in the tables, only these precomputed subset sums.

Loading follows a fixed order. A rising edge on `coef_we` restarts the load, and the word present in that cycle is tap 0. Each further cycle with `coef_we` high carries the next tap. Once the last tap is captured, a sequencer fills all tables in parallel, one address per cycle from address 0 upward. Each entry is formed from an entry already written plus one coefficient. When the sequencer finishes, `reload_done` goes high.

The reload path runs independently of the filter's synchronous reset (`filt_rst`) and of its enable (`filt_en`). Those two inputs act only on the registered read port that the filter datapath uses. Only the power-on reset `por_n` initialises the engine.

Top module: `da_coef_reload`

## Requirements
- R1: A rising edge on `coef_we` restarts capture. The word on `coef_in` in that cycle becomes tap 0, and each following consecutive cycle with `coef_we` high supplies taps 1, 2, … in order. A load cut short by dropping `coef_we` is discarded by the next rising edge.
- R2: Words presented while `coef_we` stays high after all `NUM_TAPS` coefficients have been captured are ignored and leave the tables unchanged.
- R3: Entry `a` of table `t` equals the sum of coefficients `t*TAPS_PER_TBL + j` over every bit `j` set in `a`. Coefficients are two's complement when `COEF_SIGNED`=1. Entries are `COEF_W + clog2(TAPS_PER_TBL)` bits wide and never overflow, including when every coefficient is at its minimum or maximum.
- R4: Entry 0 of every table is written first and is always zero.
- R5: `reload_done` rises exactly `2^TAPS_PER_TBL` clock cycles after the edge that captures the last tap.
- R6: A rising edge on `coef_we` clears `reload_done` one cycle later. A rising edge during table filling aborts the fill, and the new set is the one that ends up in the tables.
- R7: Loading and table filling behave identically while `filt_rst` is high and `filt_en` is low.
- R8: `tbl_rd_data` slice `t` (bits `t*ENT_W` upward) shows, one cycle after the clock edge, the table `t` entry addressed by `tbl_rd_addr` slice `t` (bits `t*TAPS_PER_TBL` upward). All tables are read independently.
- R9: While `filt_rst` is high, `tbl_rd_data` becomes zero after the next edge. While `filt_rst` is low and `filt_en` is low, `tbl_rd_data` holds its value.
- R10: After `por_n` is asserted, `reload_done` is 0 and `tbl_rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| filt_rst | input | 1 | Filter synchronous reset; clears only the read port |
| filt_en | input | 1 | Filter enable; the read port updates only when high |
| coef_we | input | 1 | Coefficient write enable; a rising edge restarts loading |
| coef_in | input | COEF_W | Coefficient word, tap order |
| tbl_rd_addr | input | NUM_TBL*TAPS_PER_TBL | One address per table, table 0 in the low bits |
| tbl_rd_data | output | NUM_TBL*ENT_W | Registered subset sums, table 0 in the low bits |
| reload_done | output | 1 | All tables filled since the last rising edge of `coef_we` |

## Verification
The assertions assume that `coef_in` holds the intended tap in every cycle where `coef_we` is high. They also assume that the filter does not rely on table contents while a fill is running. The no-overflow property further relies on entry widths derived from the coefficient width, so it holds for any coefficient values. The directed stimulus changes inputs only between clock edges. It holds `coef_we` low for at least one cycle between loads, and reads the tables only after `reload_done` is observed, so every read compares a finished table with subset sums computed in the bench.

// File: rtl/darl_pkg.sv
package darl_pkg;

   // Width of an index able to count up to and including n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   // Guard growth bits needed to add k coefficients.
   function automatic int unsigned growth_bits(input int unsigned k);
      return (k <= 1) ? 0 : $clog2(k);
   endfunction

endpackage

// File: rtl/darl_capture.sv
// Write-enable edge detection, tap slot counter and coefficient bank.
module darl_capture #(
   parameter int COEF_W   = 8,
   parameter int NUM_TAPS = 8,
   parameter int CNT_W    = 4
) (
   input  logic                       clk,
   input  logic                       por_n,
   input  logic                       coef_we,
   input  logic [COEF_W-1:0]          coef_in,
   output logic                       we_rise,
   output logic                       last_cap,
   output logic [NUM_TAPS*COEF_W-1:0] coef_bank
);

   localparam logic [CNT_W-1:0] TAPS_C = CNT_W'(NUM_TAPS);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(NUM_TAPS - 1);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   logic             we_q;
   logic [CNT_W-1:0] cap_cnt;
   logic             cap_take;
   logic [CNT_W-1:0] cap_slot;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) we_q <= 1'b0;
      else        we_q <= coef_we;
   end

   assign we_rise = coef_we & ~we_q;

   // A rising edge always lands in slot 0; otherwise fill the next free slot.
   always_comb begin
      cap_take = 1'b0;
      cap_slot = '0;
      if (we_rise) begin
         cap_take = 1'b1;
      end else if (coef_we && (cap_cnt < TAPS_C)) begin
         cap_take = 1'b1;
         cap_slot = cap_cnt;
      end
   end

   assign last_cap = cap_take && (cap_slot == LAST_C);

   // Counter idles at NUM_TAPS so stray words are dropped.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        cap_cnt <= TAPS_C;
      else if (cap_take) cap_cnt <= cap_slot + ONE_C;
   end

   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_slot
      logic [COEF_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (cap_take && (cap_slot == CNT_W'(g))) slot_q <= coef_in;
      end
      assign coef_bank[g*COEF_W +: COEF_W] = slot_q;
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
      cap_cnt <= TAPS_C);

   // R1
   restart_slot_chk: assert property (@(posedge clk) disable iff (!por_n)
      we_rise |=> (cap_cnt == ONE_C));

endmodule

// File: rtl/darl_seq.sv
// Fill sequencer: walks table addresses once all taps are captured.
module darl_seq #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             we_rise,
   input  logic             last_cap,
   output logic             bld,
   output logic [IDX_W-1:0] idx,
   output logic             done
);

   localparam logic [IDX_W-1:0] LAST_IDX = '1;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         bld  <= 1'b0;
         idx  <= '0;
         done <= 1'b0;
      end else if (we_rise) begin
         done <= 1'b0;
         idx  <= '0;
         bld  <= last_cap;
      end else if (last_cap) begin
         bld  <= 1'b1;
         idx  <= '0;
      end else if (bld) begin
         if (idx == LAST_IDX) begin
            bld  <= 1'b0;
            done <= 1'b1;
         end else begin
            idx  <= idx + IDX_W'(1);
         end
      end
   end

   // R5
   done_after_last_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(done) |-> ($past(bld) && ($past(idx) == LAST_IDX)));

   // R5
   done_excl_fill_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(bld && done));

   // R6
   done_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      we_rise |=> !done);

endmodule

// File: rtl/darl_table.sv
// One subset-sum table with its build adder and registered read port.
module darl_table #(
   parameter int COEF_W      = 8,
   parameter int K           = 4,
   parameter int ENT_W       = 10,
   parameter bit COEF_SIGNED = 1'b1
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic [K*COEF_W-1:0] coefs,
   input  logic                bld,
   input  logic [K-1:0]        idx,
   input  logic                done,
   input  logic                filt_rst,
   input  logic                filt_en,
   input  logic [K-1:0]        rd_addr,
   output logic [ENT_W-1:0]    rd_data
);

   localparam int DEPTH = 1 << K;

   logic [ENT_W-1:0]  mem [DEPTH];
   logic [K-1:0]      base_addr;
   logic [COEF_W-1:0] c_sel;
   logic [ENT_W-1:0]  c_ext;
   logic [ENT_W-1:0]  base_val;
   logic [ENT_W:0]    sum_w;
   logic              ext_top;
   logic              base_top;
   logic              ovf_ref;
   logic [ENT_W-1:0]  wr_val;

   function automatic int top_bit(input logic [K-1:0] v);
      int r;
      r = 0;
      for (int b = 0; b < K; b++) begin
         if (v[b]) r = b;
      end
      return r;
   endfunction

   // Entry i = entry(i without its top bit) + coefficient of that bit.
   always_comb begin
      base_addr = idx & ~(K'(1) << top_bit(idx));
      c_sel     = coefs[top_bit(idx)*COEF_W +: COEF_W];
      base_val  = mem[base_addr];
   end

   if (COEF_SIGNED) begin : g_signed
      assign c_ext    = ENT_W'($signed(c_sel));
      assign ext_top  = c_ext[ENT_W-1];
      assign base_top = base_val[ENT_W-1];
      assign ovf_ref  = sum_w[ENT_W-1];
   end else begin : g_unsigned
      assign c_ext    = ENT_W'(c_sel);
      assign ext_top  = 1'b0;
      assign base_top = 1'b0;
      assign ovf_ref  = 1'b0;
   end

   assign sum_w  = {base_top, base_val} + {ext_top, c_ext};
   assign wr_val = (idx == '0) ? '0 : sum_w[ENT_W-1:0];

   always_ff @(posedge clk) begin
      if (bld) mem[idx] <= wr_val;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        rd_data <= '0;
      else if (filt_rst) rd_data <= '0;
      else if (filt_en)  rd_data <= mem[rd_addr];
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!por_n)
      (bld && (idx != '0)) |-> (sum_w[ENT_W] == ovf_ref));

   // R4
   zero_head_chk: assert property (@(posedge clk) disable iff (!por_n)
      done |-> (mem[0] == '0));

   // R9
   rd_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      filt_rst |=> (rd_data == '0));

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!filt_rst && !filt_en) |=> $stable(rd_data));

endmodule

// File: rtl/da_coef_reload.sv
// Distributed-arithmetic coefficient reload engine (top).
module da_coef_reload
   import darl_pkg::*;
#(
   parameter int COEF_W       = 8,
   parameter int NUM_TAPS     = 8,
   parameter int TAPS_PER_TBL = 4,
   parameter bit COEF_SIGNED  = 1'b1,
   localparam int NUM_TBL     = NUM_TAPS / TAPS_PER_TBL,
   localparam int ENT_W       = COEF_W + growth_bits(TAPS_PER_TBL)
) (
   input  logic                            clk,
   input  logic                            por_n,
   input  logic                            filt_rst,
   input  logic                            filt_en,
   input  logic                            coef_we,
   input  logic [COEF_W-1:0]               coef_in,
   input  logic [NUM_TBL*TAPS_PER_TBL-1:0] tbl_rd_addr,
   output logic [NUM_TBL*ENT_W-1:0]        tbl_rd_data,
   output logic                            reload_done
);

   localparam int CNT_W = cnt_width(NUM_TAPS);

   if (COEF_W < 2) begin : g_bad_w
      $error("da_coef_reload: COEF_W must be at least 2");
   end
   if (TAPS_PER_TBL < 1 || TAPS_PER_TBL > 10) begin : g_bad_k
      $error("da_coef_reload: TAPS_PER_TBL must lie in 1..10");
   end
   if (NUM_TAPS < TAPS_PER_TBL || (NUM_TAPS % TAPS_PER_TBL) != 0) begin : g_bad_n
      $error("da_coef_reload: NUM_TAPS must be a multiple of TAPS_PER_TBL");
   end

   logic                       we_rise;
   logic                       last_cap;
   logic [NUM_TAPS*COEF_W-1:0] coef_bank;
   logic                       bld;
   logic [TAPS_PER_TBL-1:0]    idx;
   logic                       done;

   darl_capture #(
      .COEF_W   (COEF_W),
      .NUM_TAPS (NUM_TAPS),
      .CNT_W    (CNT_W)
   ) u_capture (
      .clk       (clk),
      .por_n     (por_n),
      .coef_we   (coef_we),
      .coef_in   (coef_in),
      .we_rise   (we_rise),
      .last_cap  (last_cap),
      .coef_bank (coef_bank)
   );

   darl_seq #(
      .IDX_W (TAPS_PER_TBL)
   ) u_seq (
      .clk      (clk),
      .por_n    (por_n),
      .we_rise  (we_rise),
      .last_cap (last_cap),
      .bld      (bld),
      .idx      (idx),
      .done     (done)
   );

   for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
      darl_table #(
         .COEF_W      (COEF_W),
         .K           (TAPS_PER_TBL),
         .ENT_W       (ENT_W),
         .COEF_SIGNED (COEF_SIGNED)
      ) u_table (
         .clk      (clk),
         .por_n    (por_n),
         .coefs    (coef_bank[t*TAPS_PER_TBL*COEF_W +: TAPS_PER_TBL*COEF_W]),
         .bld      (bld),
         .idx      (idx),
         .done     (done),
         .filt_rst (filt_rst),
         .filt_en  (filt_en),
         .rd_addr  (tbl_rd_addr[t*TAPS_PER_TBL +: TAPS_PER_TBL]),
         .rd_data  (tbl_rd_data[t*ENT_W +: ENT_W])
      );
   end

   assign reload_done = done;

endmodule

// File: tb/da_coef_reload_bench.sv
module da_coef_reload_bench;

   localparam int CLK_P = 10;
   localparam int CW    = 8;
   localparam int NT    = 8;
   localparam int K     = 4;
   localparam int NTB   = NT / K;
   localparam int EW    = CW + $clog2(K);
   localparam int DEP   = 1 << K;

   logic                clk = 1'b0;
   logic                por_n = 1'b0;
   logic                filt_rst = 1'b0;
   logic                filt_en = 1'b0;
   logic                coef_we = 1'b0;
   logic [CW-1:0]       coef_in = '0;
   logic [NTB*K-1:0]    tbl_rd_addr = '0;
   logic [NTB*EW-1:0]   tbl_rd_data;
   logic                reload_done;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   int model [NT];

   always #(CLK_P/2) clk = ~clk;

   da_coef_reload #(
      .COEF_W(CW), .NUM_TAPS(NT), .TAPS_PER_TBL(K), .COEF_SIGNED(1'b1)
   ) u_da_coef_reload (
      .clk(clk), .por_n(por_n), .filt_rst(filt_rst), .filt_en(filt_en),
      .coef_we(coef_we), .coef_in(coef_in), .tbl_rd_addr(tbl_rd_addr),
      .tbl_rd_data(tbl_rd_data), .reload_done(reload_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int subset_sum(input int t, input int a);
      int s = 0;
      for (int j = 0; j < K; j++) if (a[j]) s += model[t*K + j];
      return s;
   endfunction

   function automatic int rd_slice(input int t);
      return int'($signed(tbl_rd_data[t*EW +: EW]));
   endfunction

   // Drive a full set; extra junk words keep coef_we high afterwards.
   task automatic load_set(input int cf [NT], input int extra);
      @(negedge clk);
      coef_we = 1'b1;
      for (int i = 0; i < NT; i++) begin
         coef_in = CW'(cf[i]);
         @(negedge clk);
      end
      for (int e = 0; e < extra; e++) begin
         coef_in = CW'($urandom);
         @(negedge clk);
      end
      coef_we = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!reload_done && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic verify_tables(input string req);
      filt_en = 1'b1;
      for (int a = 0; a < DEP; a++) begin
         for (int t = 0; t < NTB; t++) tbl_rd_addr[t*K +: K] = K'(a);
         @(negedge clk);
         for (int t = 0; t < NTB; t++)
            chk(rd_slice(t) == subset_sum(t, a), req, rd_slice(t), subset_sum(t, a));
      end
   endtask

   task automatic rand_set(output int cf [NT]);
      for (int i = 0; i < NT; i++) cf[i] = int'($signed(CW'($urandom)));
   endtask

   task automatic t_reset();
      chk(reload_done == 1'b0, "R10 done after reset", int'(reload_done), 0);
      chk(tbl_rd_data == '0, "R10 read port after reset", int'(tbl_rd_data), 0);
   endtask

   task automatic t_basic();
      int cf [NT];
      int n;
      rand_set(cf);
      model = cf;
      load_set(cf, 0);
      wait_done(n);
      chk(n == DEP, "R5 done latency", n, DEP);
      verify_tables("R3 R4 R8 basic table");
   endtask

   task automatic t_extremes();
      int cf [NT];
      int n;
      for (int i = 0; i < NT; i++) cf[i] = -(1 << (CW-1));
      model = cf;
      load_set(cf, 0);
      wait_done(n);
      verify_tables("R3 all minimum");
      for (int i = 0; i < NT; i++) cf[i] = (1 << (CW-1)) - 1;
      model = cf;
      load_set(cf, 0);
      wait_done(n);
      verify_tables("R3 all maximum");
      tbl_rd_addr = '0;
      @(negedge clk);
      chk(rd_slice(0) == 0, "R4 entry zero", rd_slice(0), 0);
   endtask

   task automatic t_under_reset();
      int cf [NT];
      int n;
      rand_set(cf);
      model = cf;
      filt_rst = 1'b1;
      filt_en  = 1'b0;
      load_set(cf, 0);
      wait_done(n);
      chk(n == DEP, "R7 fill under filter reset", n, DEP);
      chk(tbl_rd_data == '0, "R9 cleared under reset", int'(tbl_rd_data), 0);
      filt_rst = 1'b0;
      verify_tables("R7 tables after load under reset");
   endtask

   task automatic t_extra_words();
      int cf [NT];
      int n;
      rand_set(cf);
      model = cf;
      load_set(cf, 3);
      wait_done(n);
      verify_tables("R2 trailing words ignored");
   endtask

   task automatic t_partial_restart();
      int a [NT];
      int b [NT];
      int n;
      rand_set(a);
      rand_set(b);
      @(negedge clk);
      coef_we = 1'b1;
      for (int i = 0; i < 3; i++) begin
         coef_in = CW'(a[i] + 1);
         @(negedge clk);
      end
      coef_we = 1'b0;
      model = b;
      load_set(b, 0);
      wait_done(n);
      chk(n == DEP, "R1 restart after partial load", n, DEP);
      verify_tables("R1 new set in order");
   endtask

   task automatic t_mid_fill_restart();
      int a [NT];
      int b [NT];
      int n;
      rand_set(a);
      rand_set(b);
      // clear done with a fresh edge
      @(negedge clk);
      coef_we = 1'b1;
      coef_in = CW'(a[0]);
      @(negedge clk);
      chk(reload_done == 1'b0, "R6 done cleared by edge", int'(reload_done), 0);
      for (int i = 1; i < NT; i++) begin
         coef_in = CW'(a[i]);
         @(negedge clk);
      end
      coef_we = 1'b0;
      repeat (5) @(negedge clk);
      model = b;
      load_set(b, 0);
      wait_done(n);
      chk(n == DEP, "R6 fill restarted", n, DEP);
      verify_tables("R6 aborted fill replaced");
   endtask

   task automatic t_read_port();
      filt_en = 1'b1;
      tbl_rd_addr[0 +: K] = K'(3);
      tbl_rd_addr[K +: K] = K'(12);
      @(negedge clk);
      chk(rd_slice(0) == subset_sum(0, 3), "R8 table 0 independent", rd_slice(0), subset_sum(0, 3));
      chk(rd_slice(1) == subset_sum(1, 12), "R8 table 1 independent", rd_slice(1), subset_sum(1, 12));
      filt_en = 1'b0;
      tbl_rd_addr[0 +: K] = K'(15);
      tbl_rd_addr[K +: K] = K'(1);
      repeat (2) @(negedge clk);
      chk(rd_slice(0) == subset_sum(0, 3), "R9 hold when disabled", rd_slice(0), subset_sum(0, 3));
      chk(rd_slice(1) == subset_sum(1, 12), "R9 hold when disabled", rd_slice(1), subset_sum(1, 12));
      filt_rst = 1'b1;
      @(negedge clk);
      chk(tbl_rd_data == '0, "R9 clear on filter reset", int'(tbl_rd_data), 0);
      filt_rst = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      por_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_extremes();
      t_under_reset();
      t_extra_words();
      t_partial_restart();
      t_mid_fill_restart();
      t_read_port();
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

endmodule